// File: doc/BRIEF.md
# Dual Gated Clock Divider

This block takes one slow clock signal, sampled inside a single fast system clock domain, and produces two banks of four gate outputs. Every gate output is the level of the incoming clock ANDed with one bit of a binary counter, so each output pulse has the same width as an input clock pulse. The first bank is a plain binary divider that no control can change. It gives divisions by 2, 4, 8 and 16.

The second bank has its own counter. After reset it starts from the same value as the first bank's counter. The mode gate picks what advances it. It can step on every input clock, or only when the first bank's slowest stage rises, which stretches its divisions by sixteen. Its bits pass through a selectable bitwise logic stage before the gating. That stage combines each counter bit with a control word using one of four operations. A flip gate makes the second counter stop counting and track an external 4-bit code. When flip drops, counting resumes from the last code loaded.

Top module: `dual_gate_divider`

## Requirements
- R1: Counter A advances by one on each rising edge of the synchronised input clock. `gate_a[i]` is high exactly when the synchronised clock level is high and bit i of counter A is set, which gives divide-by-2, 4, 8 and 16 on bits 0 to 3.
- R2: `gate_a` does not depend on `mode`, `op_sel`, `ctrl`, `flip` or `flip_code`.
- R3: `clk_in` passes through two synchroniser flops and one edge-history flop. A rise of `clk_in` set up before system clock edge n shows on the gate outputs after edge n+2 and not earlier.
- R4: With `mode` low and `flip` low, counter B advances on every synchronised input clock rise. After reset it holds the same value as counter A.
- R5: With `mode` high and `flip` low, counter B advances only on the input clock rise that takes counter A from 7 to 8, which is the rise of its divide-by-16 stage.
- R6: `gate_b[i]` is the synchronised clock level ANDed with f(b[i], ctrl[i]), where `op_sel` selects f: 0 = NOR, 1 = NAND, 2 = XOR, 3 = XNOR.
- R7: While `flip` is high, counter B loads `flip_code` on every system clock and does not count.
- R8: When `flip` falls, counter B resumes counting from the last code it loaded.
- R9: Synchronous reset clears both counters and the synchroniser, and holds every gate output low while `rst` is high.
- R10: With `op_sel` = XOR and `ctrl` = 0, `gate_b` equals `gate_a` whenever the two counters hold equal values.
- R11: With `mode` high, XOR and `ctrl` all ones, `gate_b` follows the clock pulses on the inverted bits of counter B. The active subset changes once every 16 input clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_in | input | 1 | Asynchronous input clock to divide |
| mode | input | 1 | Bank B step source: 0 = every input clock, 1 = divide-by-16 rise |
| op_sel | input | 2 | Bank B logic operation: 0 NOR, 1 NAND, 2 XOR, 3 XNOR |
| ctrl | input | 4 | Control word combined bitwise with counter B |
| flip | input | 1 | When high, counter B follows flip_code |
| flip_code | input | 4 | External code followed while flip is high |
| gate_a | output | 4 | Bank A gates, divide-by-2/4/8/16 |
| gate_b | output | 4 | Bank B gates after the logic stage |

## Verification
The hardest state to reach from the ports is counter B in divide-by-16 mode, sitting at a code that flip has forced, so that it is offset from counter A. From there the bench must see the exact input clock that carries counter A from 7 to 8 step counter B. The stimulus reaches this state in order. It first loads an arbitrary code through flip while input pulses keep arriving. It then drops flip and runs enough whole input pulses, with the mode gate high, to cross several divide-by-16 boundaries. A behavioural reference model, advanced on every system clock, predicts both banks. Meanwhile the operation select and control word are changed between pulses.

// File: rtl/dgd_pkg.sv
package dgd_pkg;

    localparam int DIV_STAGES = 4;

    typedef enum logic [1:0] {
        OP_NOR  = 2'd0,
        OP_NAND = 2'd1,
        OP_XOR  = 2'd2,
        OP_XNOR = 2'd3
    } op_e;

    typedef struct packed {
        logic meta;
        logic sync;
        logic lvl;
    } sync_st_t;

endpackage

// File: rtl/dgd_edge_sync.sv
module dgd_edge_sync
    import dgd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level_o,
    output logic rise_o
);

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_in;
        st_d.sync = st_q.meta;
        st_d.lvl  = st_q.sync;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign level_o = st_q.lvl;
    assign rise_o  = st_q.sync & ~st_q.lvl;

    // R3
    rise_level_chk: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> level_o);

endmodule

// File: rtl/dgd_logic_stage.sv
module dgd_logic_stage
    import dgd_pkg::*;
#(
    parameter int W = 4
) (
    input  op_e          op,
    input  logic [W-1:0] word,
    input  logic [W-1:0] bits_i,
    output logic [W-1:0] bits_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            unique case (op)
                OP_NOR:  bits_o[i] = ~(bits_i[i] | word[i]);
                OP_NAND: bits_o[i] = ~(bits_i[i] & word[i]);
                OP_XOR:  bits_o[i] = bits_i[i] ^ word[i];
                OP_XNOR: bits_o[i] = ~(bits_i[i] ^ word[i]);
                default: bits_o[i] = bits_i[i];
            endcase
        end
    end

    // R10
    always_comb begin
        if (op == OP_XOR && word == '0) begin
            xor_pass_chk: assert (bits_o == bits_i);
        end
    end

endmodule

// File: rtl/dual_gate_divider.sv
module dual_gate_divider
    import dgd_pkg::*;
#(
    parameter int W = DIV_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clk_in,
    input  logic         mode,
    input  logic [1:0]   op_sel,
    input  logic [W-1:0] ctrl,
    input  logic         flip,
    input  logic [W-1:0] flip_code,
    output logic [W-1:0] gate_a,
    output logic [W-1:0] gate_b
);

    localparam logic [W-1:0] MSB_PRE = {1'b0, {(W-1){1'b1}}};

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
    } cnt_st_t;

    cnt_st_t cnt_d, cnt_q;
    logic    lvl, rise, msb_rise, step_b;
    logic [W-1:0] b_mod;

    dgd_edge_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (clk_in),
        .level_o  (lvl),
        .rise_o   (rise)
    );

    always_comb begin
        cnt_d    = cnt_q;
        msb_rise = rise && (cnt_q.a == MSB_PRE);
        step_b   = mode ? msb_rise : rise;
        if (rise) begin
            cnt_d.a = cnt_q.a + 1'b1;
        end
        if (flip) begin
            cnt_d.b = flip_code;
        end else if (step_b) begin
            cnt_d.b = cnt_q.b + 1'b1;
        end
        if (rst) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    dgd_logic_stage #(.W(W)) u_logic (
        .op     (op_e'(op_sel)),
        .word   (ctrl),
        .bits_i (cnt_q.b),
        .bits_o (b_mod)
    );

    assign gate_a = {W{lvl & ~rst}} & cnt_q.a;
    assign gate_b = {W{lvl & ~rst}} & b_mod;

    // R1
    a_step_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> cnt_q.a == $past(cnt_q.a) + 1'b1);

    // R4
    b_every_clk_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode && !flip && rise) |=> cnt_q.b == $past(cnt_q.b) + 1'b1);

    // R5
    b_slow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode && !flip && !msb_rise) |=> $stable(cnt_q.b));

    // R7
    b_follow_chk: assert property (@(posedge clk) disable iff (rst)
        flip |=> cnt_q.b == $past(flip_code));

    // R9
    always_comb begin
        if (rst) begin
            rst_quiet_chk: assert (gate_a == '0 && gate_b == '0);
        end
    end

endmodule

// File: tb/dual_gate_divider_tb.sv
module dual_gate_divider_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_in = 1'b0;
    logic       mode = 1'b0;
    logic [1:0] op_sel = 2'd2;
    logic [3:0] ctrl = 4'h0;
    logic       flip = 1'b0;
    logic [3:0] flip_code = 4'h0;
    logic [3:0] gate_a, gate_b;

    int total = 0;
    int bad = 0;
    bit live = 1'b0;
    bit done = 1'b0;
    string tag_b = "R4";

    always #4 clk = ~clk;

    dual_gate_divider u_dut (
        .clk(clk), .rst(rst), .clk_in(clk_in), .mode(mode), .op_sel(op_sel),
        .ctrl(ctrl), .flip(flip), .flip_code(flip_code),
        .gate_a(gate_a), .gate_b(gate_b)
    );

    // behavioural reference: input history queue plus integer counters
    bit   hist[$] = '{0, 0, 0};
    int   ca = 0, cb = 0;

    function automatic logic [3:0] ref_op(input logic [1:0] s, input logic [3:0] c, input logic [3:0] w);
        case (s)
            2'd0: return ~(c | w);
            2'd1: return ~(c & w);
            2'd2: return c ^ w;
            default: return ~(c ^ w);
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            hist = '{0, 0, 0};
            ca = 0;
            cb = 0;
        end else begin
            bit edge_seen;
            bit slow_edge;
            edge_seen = hist[1] && !hist[2];
            slow_edge = edge_seen && (ca % 16 == 7);
            if (flip) cb = int'(flip_code);
            else if (mode ? slow_edge : edge_seen) cb = (cb + 1) % 16;
            if (edge_seen) ca = (ca + 1) % 16;
            hist.push_front(clk_in);
            void'(hist.pop_back());
        end
    end

    task automatic check(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (live) begin
            logic [3:0] ea, eb;
            ea = (rst || !hist[2]) ? 4'h0 : 4'(ca);
            eb = (rst || !hist[2]) ? 4'h0 : ref_op(op_sel, 4'(cb), ctrl);
            check(gate_a === ea, "R1 R2", gate_a, ea);
            check(gate_b === eb, tag_b, gate_b, eb);
        end
    end

    task automatic pulses(input int n, input bit cmp_eq);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) clk_in = 1'b1;
            repeat (3) @(negedge clk);
            if (cmp_eq) check(gate_a === gate_b, "R10", gate_b, gate_a);
            clk_in = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(gate_a === 4'h0 && gate_b === 4'h0, "R9", gate_a | gate_b, 4'h0);
        live = 1'b1;
        @(negedge clk) rst = 1'b0;
        repeat (2) @(negedge clk);

        // R3 latency: rise set before edge n, visible after edge n+2
        clk_in = 1'b1;
        @(posedge clk); #2;
        @(posedge clk); #2;
        check(gate_a === 4'h0, "R3", gate_a, 4'h0);
        @(posedge clk); #2;
        check(gate_a === 4'h1, "R3", gate_a, 4'h1);
        @(negedge clk) clk_in = 1'b0;
        repeat (3) @(negedge clk);

        tag_b = "R4 R10";
        pulses(20, 1'b1);

        tag_b = "R6";
        for (int s = 0; s < 4; s++) begin
            op_sel = 2'(s);
            ctrl = 4'(4'h5 + s * 3);
            pulses(5, 1'b0);
        end

        tag_b = "R7 R2";
        @(negedge clk) flip = 1'b1; flip_code = 4'hA; mode = 1'b1;
        pulses(3, 1'b0);
        flip_code = 4'h3; op_sel = 2'd0;
        pulses(2, 1'b0);

        tag_b = "R8 R5";
        @(negedge clk) flip = 1'b0; op_sel = 2'd2; ctrl = 4'h0;
        pulses(40, 1'b0);

        tag_b = "R11";
        ctrl = 4'hF;
        pulses(40, 1'b0);

        tag_b = "R8";
        mode = 1'b0; flip = 1'b1; flip_code = 4'hE;
        pulses(1, 1'b0);
        flip = 1'b0;
        pulses(4, 1'b0);

        tag_b = "R9";
        @(negedge clk) clk_in = 1'b1; rst = 1'b1;
        repeat (4) @(negedge clk);
        check(gate_a === 4'h0 && gate_b === 4'h0, "R9", gate_a | gate_b, 4'h0);
        rst = 1'b0; clk_in = 1'b0;
        repeat (4) @(negedge clk);
        live = 1'b0;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 4'h0, 4'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule